// File: doc/BRIEF.md
# Flash Read-Path SECDED Checker

This block sits on the read path of a flash array. Each fetched word is 72 bits: 64 data bits and 8 stored check bits. The block recomputes the check bits from the data, XORs them with the stored ones to form an 8-bit syndrome, and sorts the fetch into one of five classes: clean, single check-bit error, single data-bit error, double-bit error, or multi-bit error. A single data-bit error is corrected on the returned data. A single check-bit error passes the data through unchanged.

Every request gets a registered response one cycle later. The response carries the corrected data, the class, and an abort pulse. The abort fires only for an uncorrectable fetch that the requester will actually consume. Fetches marked speculative never abort, but they still update the sticky status. That status is a correctable flag, an uncorrectable flag and a 2-bit class field. It holds until a clear pulse. A diagnostic mask input XORs onto the stored check bits before checking, so that check-bit corruption can be injected without touching the array.

Top module: `flash_ecc_chk`

## Requirements
- R1: The code column of data bit i is the i-th value, in ascending numeric order, among the 8-bit values of weight 3, followed by those of weight 5. Check bit j has column 1<<j. The syndrome is the stored check bits XOR diag_mask_i XOR the XOR of the columns of all set data bits.
- R2: A zero syndrome gives class 0 (clean). The data is returned unchanged and no status flag is set.
- R3: A syndrome of weight 1 gives class 1 (check-bit error). The data is returned unchanged and the correctable flag is set.
- R4: A syndrome equal to the column of data bit i gives class 2 (data-bit error), and bit i of the returned data is inverted.
- R5: A nonzero syndrome of even weight gives class 3 (double-bit error) and sets the uncorrectable flag.
- R6: A syndrome of odd weight that matches no column gives class 4 (multi-bit error) and sets the uncorrectable flag.
- R7: rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high. rsp_data_o and rsp_cls_o belong to that request.
- R8: abort_o is high together with a response only when the request was not speculative and its class is 3 or 4. It is low in every other cycle.
- R9: A speculative request (req_spec_i=1) never raises abort_o, yet it sets the status flag matching its class.
- R10: Classes 1 and 2 never set the uncorrectable flag.
- R11: The flags are sticky until clr_i. err_cls_o records the first error after a clear: 01 for a correctable error, 10 for a double-bit error, 11 for a multi-bit error, 00 for none. When clr_i coincides with a request, the clear wins and that request's event is dropped.
- R12: diag_mask_i is XORed onto req_chk_i before checking. With correctly encoded data the syndrome equals the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Read word presented this cycle |
| req_spec_i | input | 1 | Fetch is speculative and will not be consumed |
| req_data_i | input | 64 | Data bits read from the array |
| req_chk_i | input | 8 | Stored check bits read from the array |
| diag_mask_i | input | 8 | Diagnostic XOR mask onto the stored check bits |
| clr_i | input | 1 | Clears the sticky status |
| rsp_valid_o | output | 1 | Response valid |
| rsp_data_o | output | 64 | Corrected data |
| rsp_cls_o | output | 3 | Error class of the response (0 to 4) |
| abort_o | output | 1 | Bus abort for a consumed uncorrectable fetch |
| corr_flag_o | output | 1 | Sticky correctable-error flag |
| unc_flag_o | output | 1 | Sticky uncorrectable-error flag |
| err_cls_o | output | 2 | Class of the first error since the last clear |

## Verification
The assertions assume that every input is driven to a known value from reset onward. The pass-through checks compare the response with the request data of the cycle before, so they also assume that request data is defined whenever req_valid_i is high. The stimulus drives all inputs on the falling edge and holds them stable over the capturing edge. It sweeps all 256 diagnostic masks over correctly encoded data, flips each data bit in turn, and mixes in random words with random check bits, random speculative marking and occasional clears. Some clears land in the same cycle as an uncorrectable request.

// File: rtl/flash_ecc_pkg.sv
package flash_ecc_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int TAB_W  = DATA_W * CHK_W;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_CHK  = 3'd1,
    CLS_DAT  = 3'd2,
    CLS_DBL  = 3'd3,
    CLS_MUL  = 3'd4
  } ecc_cls_e;

  function automatic int pop_cnt(int v);
    int n = 0;
    for (int b = 0; b < CHK_W; b++) n += (v >> b) & 1;
    return n;
  endfunction

  // odd-weight columns: all weight-3 values ascending, then weight-5
  function automatic logic [TAB_W-1:0] build_tab();
    logic [TAB_W-1:0] t = '0;
    int n = 0;
    for (int w = 3; w <= CHK_W; w += 2)
      for (int v = 0; v < (1 << CHK_W); v++)
        if (pop_cnt(v) == w && n < DATA_W) begin
          t[n*CHK_W +: CHK_W] = v[CHK_W-1:0];
          n++;
        end
    return t;
  endfunction

  localparam logic [TAB_W-1:0] COL_TAB = build_tab();
endpackage

// File: rtl/flash_ecc_syn.sv
module flash_ecc_syn
  import flash_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  input  logic [CHK_W-1:0]  mask_i,
  output logic [CHK_W-1:0]  syn_o
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_row
    logic [DATA_W-1:0] row;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign row[i] = COL_TAB[i*CHK_W + j];
    end
    assign syn_o[j] = (^(data_i & row)) ^ chk_i[j] ^ mask_i[j];
  end
endmodule

// File: rtl/flash_ecc_cls.sv
module flash_ecc_cls
  import flash_ecc_pkg::*;
(
  input  logic [CHK_W-1:0]  syn_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output ecc_cls_e          cls_o
);
  logic [DATA_W-1:0] hit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_hit
    assign hit[i] = (syn_i == COL_TAB[i*CHK_W +: CHK_W]);
  end

  always_comb begin
    if (syn_i == '0)         cls_o = CLS_NONE;
    else if ($onehot(syn_i)) cls_o = CLS_CHK;
    else if (|hit)           cls_o = CLS_DAT;
    else if (!(^syn_i))      cls_o = CLS_DBL;
    else                     cls_o = CLS_MUL;
  end

  // hit is zero unless the syndrome names a data column
  assign data_o = data_i ^ hit;
endmodule

// File: rtl/flash_ecc_sts.sv
module flash_ecc_sts
  import flash_ecc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ev_i,
  input  ecc_cls_e cls_i,
  input  logic     clr_i,
  output logic     corr_o,
  output logic     unc_o,
  output logic [1:0] cls_o
);
  logic corr_ev, unc_ev;
  logic [1:0] code;

  assign corr_ev = ev_i && (cls_i == CLS_CHK || cls_i == CLS_DAT);
  assign unc_ev  = ev_i && (cls_i == CLS_DBL || cls_i == CLS_MUL);

  always_comb begin
    unique case (cls_i)
      CLS_CHK, CLS_DAT: code = 2'b01;
      CLS_DBL:          code = 2'b10;
      CLS_MUL:          code = 2'b11;
      default:          code = 2'b00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_o <= 1'b0;
      unc_o  <= 1'b0;
      cls_o  <= 2'b00;
    end else if (clr_i) begin
      corr_o <= 1'b0;
      unc_o  <= 1'b0;
      cls_o  <= 2'b00;
    end else begin
      if (corr_ev) corr_o <= 1'b1;
      if (unc_ev)  unc_o  <= 1'b1;
      if ((corr_ev || unc_ev) && !corr_o && !unc_o) cls_o <= code;
    end
  end

  AST_CORR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o && !clr_i |=> corr_o); // R11
  AST_UNC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_o && !clr_i |=> unc_o); // R11
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !corr_o && !unc_o && cls_o == 2'b00); // R11
  AST_FIRST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o || unc_o) && !clr_i |=> $stable(cls_o)); // R11
  AST_CORR_NO_UNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_ev && !unc_o && !clr_i |=> !unc_o); // R10
endmodule

// File: rtl/flash_ecc_chk.sv
module flash_ecc_chk
  import flash_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_spec_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [CHK_W-1:0]  req_chk_i,
  input  logic [CHK_W-1:0]  diag_mask_i,
  input  logic              clr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [2:0]        rsp_cls_o,
  output logic              abort_o,
  output logic              corr_flag_o,
  output logic              unc_flag_o,
  output logic [1:0]        err_cls_o
);
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] fix_data;
  ecc_cls_e          cls;
  logic              unc_now;

  flash_ecc_syn u_syn (
    .data_i (req_data_i),
    .chk_i  (req_chk_i),
    .mask_i (diag_mask_i),
    .syn_o  (syn)
  );

  flash_ecc_cls u_cls (
    .syn_i  (syn),
    .data_i (req_data_i),
    .data_o (fix_data),
    .cls_o  (cls)
  );

  flash_ecc_sts u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (req_valid_i),
    .cls_i  (cls),
    .clr_i  (clr_i),
    .corr_o (corr_flag_o),
    .unc_o  (unc_flag_o),
    .cls_o  (err_cls_o)
  );

  assign unc_now = (cls == CLS_DBL) || (cls == CLS_MUL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_cls_o   <= CLS_NONE;
      abort_o     <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      abort_o     <= req_valid_i && !req_spec_i && unc_now;
      if (req_valid_i) begin
        rsp_data_o <= fix_data;
        rsp_cls_o  <= cls;
      end
    end
  end

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R7
  AST_SPEC_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_spec_i |=> !abort_o); // R9
  AST_ABORT_UNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> rsp_valid_o && (rsp_cls_o == CLS_DBL || rsp_cls_o == CLS_MUL)); // R8
  AST_CHK_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_cls_o == CLS_CHK |-> rsp_data_o == $past(req_data_i)); // R3
  AST_CLEAN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_cls_o == CLS_NONE |-> rsp_data_o == $past(req_data_i)); // R2
endmodule

// File: tb/flash_ecc_chk_tb.sv
module flash_ecc_chk_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_spec = 1'b0, clr = 1'b0;
  logic [63:0] req_data = '0;
  logic [7:0]  req_chk = '0, diag_mask = '0;
  logic        rsp_valid, abort, corr_flag, unc_flag;
  logic [63:0] rsp_data;
  logic [2:0]  rsp_cls;
  logic [1:0]  err_cls;

  int n_chk = 0, n_bad = 0;
  logic [7:0] col_tab [64];
  bit m_corr = 0, m_unc = 0;
  logic [1:0] m_cls = 2'b00;

  always #4 clk = ~clk;

  flash_ecc_chk dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_spec_i(req_spec),
    .req_data_i(req_data), .req_chk_i(req_chk), .diag_mask_i(diag_mask), .clr_i(clr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_cls_o(rsp_cls),
    .abort_o(abort), .corr_flag_o(corr_flag), .unc_flag_o(unc_flag), .err_cls_o(err_cls)
  );

  function automatic int wt(logic [7:0] v);
    int n = 0;
    for (int b = 0; b < 8; b++) if (v[b]) n++;
    return n;
  endfunction

  function automatic logic [7:0] enc(logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= col_tab[i];
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [63:0] d, input logic [7:0] c, m, input bit spec,
                      input bit do_clr, input string grp);
    logic [7:0]  syn;
    logic [63:0] ed;
    int          ec, idx;
    string       ct;
    bit          unc;
    syn = enc(d) ^ c ^ m;
    ed = d; idx = -1;
    for (int i = 0; i < 64; i++) if (col_tab[i] == syn) idx = i;
    if (syn == 0)          begin ec = 0; ct = "R2"; end
    else if (wt(syn) == 1) begin ec = 1; ct = "R3"; end
    else if (idx >= 0)     begin ec = 2; ct = "R4"; ed[idx] = ~ed[idx]; end
    else if (!wt(syn)[0])  begin ec = 3; ct = "R5"; end
    else                   begin ec = 4; ct = "R6"; end
    unc = (ec >= 3);
    if (do_clr) begin
      m_corr = 0; m_unc = 0; m_cls = 2'b00;
    end else if (ec != 0) begin
      if (!m_corr && !m_unc) m_cls = (ec <= 2) ? 2'b01 : (ec == 3) ? 2'b10 : 2'b11;
      if (unc) m_unc = 1; else m_corr = 1;
    end
    @(negedge clk);
    req_valid = 1; req_data = d; req_chk = c; diag_mask = m; req_spec = spec; clr = do_clr;
    @(negedge clk);
    req_valid = 0; clr = 0;
    chk(rsp_valid === 1'b1, {grp, " R7 valid"}, 64'(rsp_valid), 1);
    chk(rsp_cls === 3'(ec), {grp, " ", ct, " class"}, 64'(rsp_cls), 64'(ec));
    chk(rsp_data === ed, {grp, " ", (ec == 2) ? "R4" : "R1", " data"}, rsp_data, ed);
    chk(abort === (unc && !spec), {grp, spec ? " R9" : " R8", " abort"},
        64'(abort), 64'(unc && !spec));
    chk(unc_flag === m_unc, {grp, (ec inside {1, 2}) ? " R10" : " R9", " unc flag"},
        64'(unc_flag), 64'(m_unc));
    chk(corr_flag === m_corr, {grp, " R11 corr flag"}, 64'(corr_flag), 64'(m_corr));
    chk(err_cls === m_cls, {grp, " R11 first class"}, 64'(err_cls), 64'(m_cls));
    @(negedge clk);
    chk(abort === 1'b0 && rsp_valid === 1'b0, {grp, " R8 abort one cycle"},
        64'({abort, rsp_valid}), 0);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    m_corr = 0; m_unc = 0; m_cls = 2'b00;
    chk(!corr_flag && !unc_flag && err_cls == 2'b00, "R11 clear", 64'({corr_flag, unc_flag, err_cls}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    int n = 0;
    void'($urandom(32'h5eed_0123));
    for (int w = 3; w <= 5; w += 2)
      for (int v = 0; v < 256; v++)
        if (wt(8'(v)) == w && n < 64) begin col_tab[n] = 8'(v); n++; end
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !abort && !corr_flag && !unc_flag && err_cls == 0,
        "R11 reset state", 64'({rsp_valid, abort, corr_flag, unc_flag, err_cls}), 0);
    rst_n = 1;
    // directed corner cases
    d = 64'h0123_4567_89ab_cdef;
    xact(d, enc(d), 8'h00, 0, 0, "R1 clean");
    xact(d, enc(d), 8'h01, 0, 0, "R12 m01");
    xact(d, enc(d), 8'h03, 0, 0, "R12 m03");
    do_clear();
    xact(d, enc(d), 8'h30, 1, 0, "R12 m30 spec");
    xact(d, enc(d), 8'h07, 0, 0, "R12 m07");
    do_clear();
    xact(d, enc(d), 8'h7f, 0, 0, "R12 m7f");
    xact(d, enc(d), 8'hff, 0, 0, "R12 mff");
    xact(d, enc(d), 8'h03, 0, 1, "R11 clr same cycle");
    // every diagnostic mask over good data
    for (int m = 0; m < 256; m++) begin
      d = {$urandom, $urandom};
      if (m % 16 == 0) do_clear();
      xact(d, enc(d), 8'(m), m[0], 0, "R12 sweep");
    end
    // every single data-bit flip
    for (int i = 0; i < 64; i++) begin
      d = {$urandom, $urandom};
      if (i % 8 == 0) do_clear();
      xact(d ^ (64'd1 << i), enc(d), 8'h00, 0, 0, "R4 flip");
    end
    // random words with random check bits
    for (int k = 0; k < 400; k++) begin
      d = {$urandom, $urandom};
      if ($urandom % 10 == 0) do_clear();
      xact(d, 8'($urandom), ($urandom % 4 == 0) ? 8'($urandom) : 8'h00,
           1'($urandom), ($urandom % 20 == 0), "rand");
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule